// File: doc/BRIEF.md
# Partitioned Ping-Pong Register File

This block holds the 32 architectural registers of one two-unit VLIW cluster. One unit moves data to and from memory (the load/store unit, LS). The other computes (the arithmetic unit, AU). The registers fall into four physical groups of eight:

- address registers, reachable only from LS;
- accumulators, reachable only from AU;
- two data banks, called ping and pong, which the two units share by exclusive swapping.

A one-bit bank index arrives with every packet. With index 0, LS works on ping and AU works on pong. With index 1, the roles are reversed. Each unit addresses a 16-entry space of its own, in which the same register names mean different physical data registers depending on the index.

Every group is built from two four-entry half-banks, one for even and one for odd register numbers. Each half-bank has two read ports and one write port. Reads are delivered as even/odd pairs. A unit can also write an even/odd pair in one cycle. A dual load (pair into data plus two address updates) or a dual MAC (two data pairs read plus an accumulator pair written) therefore needs no more than one write per half-bank.

Top module: `pingpong_rf`

## Requirements
- R1: After reset, every register reads as zero.
- R2: Unit addresses are 4 bits wide. Bit 3 = 0 selects the unit's private group and bit 3 = 1 selects its data bank; bits 2:0 give the register number. With bankSel = 0, the LS data bank is ping and the AU data bank is pong; with bankSel = 1, they are swapped.
- R3: LS private group is the address registers and AU private group is the accumulators. The same private name in the two units reaches two different registers.
- R4: A read port returns a 2*DATA_W pair. Bits [DATA_W-1:0] hold register (addr with bit 0 cleared) and the upper half holds register (addr with bit 0 set).
- R5: A paired write to even base m stores the low data half into m and the high half into m+1.
- R6: A paired write with an odd base raises that unit's wrErr in the same cycle, and none of that unit's writes in that cycle take effect.
- R7: If two enabled writes of one unit would hit the same half-bank (same group, same parity; a pair counts as both parities), wrErr rises and none of that unit's writes in the cycle take effect. The other unit is unaffected.
- R8: A pair write into the data bank together with two single writes of opposite parity into the address group all land in one cycle without error.
- R9: Two pair reads of the data bank and a pair write into the accumulators in one cycle all work without error.
- R10: A read in the cycle of a write to the same register returns the old value; the new value is visible from the next cycle.
- R11: A write lands in the bank chosen by bankSel in its own cycle. A changed bankSel applies to every access from the next packet on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bankSel | input | 1 | Per-packet bank index |
| lsRdAddrA | input | 4 | LS read port A address |
| lsRdAddrB | input | 4 | LS read port B address |
| lsRdDataA | output | 2*DATA_W | LS read port A pair |
| lsRdDataB | output | 2*DATA_W | LS read port B pair |
| lsPairWrEn | input | 1 | LS paired write enable |
| lsPairWrAddr | input | 4 | LS paired write base |
| lsPairWrData | input | 2*DATA_W | LS paired write data {m+1, m} |
| lsSglWrEn | input | 2 | LS single write enables |
| lsSglWrAddr | input | 2x4 | LS single write addresses |
| lsSglWrData | input | 2xDATA_W | LS single write data |
| lsWrErr | output | 1 | LS write request illegal this cycle |
| auRdAddrA | input | 4 | AU read port A address |
| auRdAddrB | input | 4 | AU read port B address |
| auRdDataA | output | 2*DATA_W | AU read port A pair |
| auRdDataB | output | 2*DATA_W | AU read port B pair |
| auPairWrEn | input | 1 | AU paired write enable |
| auPairWrAddr | input | 4 | AU paired write base |
| auPairWrData | input | 2*DATA_W | AU paired write data {m+1, m} |
| auSglWrEn | input | 2 | AU single write enables |
| auSglWrAddr | input | 2x4 | AU single write addresses |
| auSglWrData | input | 2xDATA_W | AU single write data |
| auWrErr | output | 1 | AU write request illegal this cycle |

## Verification
The assertions check several properties on every cycle:
- an odd pair base always raises the error;
- a rejected cycle leaves the LS view of the registers unchanged;
- an accepted pair write reads back on the next cycle;
- data written by LS appears to AU under the same name right after a bank swap.

Other behaviours appear only in the bench's scenarios: reset contents, the separation of the two private groups, the same-parity conflict rule, the full dual-load and dual-MAC combinations, and read-before-write timing. The bench's cycle model shows them by comparing all four read pairs and both error flags against its own register image on every clock, through directed packets and a long stretch of mixed legal and illegal traffic.

// File: rtl/pprf_pkg.sv
package pprf_pkg;
  localparam int GROUP_REGS = 8;
  localparam int NUM_GROUPS = 4;
  localparam int NUM_UNITS  = 2;
  localparam int RD_PORTS   = 2;
  localparam int SGL_PORTS  = 2;
  localparam int HALF_DEPTH = GROUP_REGS / 2;
  localparam int IDX_W      = $clog2(HALF_DEPTH);
  localparam int ADDR_W     = $clog2(2 * GROUP_REGS);
  localparam int GRP_W      = $clog2(NUM_GROUPS);
  localparam int SRC_W      = $clog2(SGL_PORTS + 1);

  // physical group numbering
  localparam logic [GRP_W-1:0] GRP_ADR  = 2'd0;
  localparam logic [GRP_W-1:0] GRP_ACC  = 2'd1;
  localparam logic [GRP_W-1:0] GRP_PING = 2'd2;
  localparam logic [GRP_W-1:0] GRP_PONG = 2'd3;

  // one write strobe per half-bank; src 0 = pair port, 1.. = single ports
  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] idx;
    logic             unit;
    logic [SRC_W-1:0] src;
  } wrStrb_t;

  typedef struct packed {
    wrStrb_t [NUM_GROUPS-1:0][1:0]                   wr;
    logic [NUM_GROUPS-1:0][RD_PORTS-1:0][IDX_W-1:0]  rdIdx;
    logic [NUM_UNITS-1:0][RD_PORTS-1:0][GRP_W-1:0]   rdGrp;
  } ctrlStrb_t;

  // unit 0 = LS, unit 1 = AU
  function automatic logic [GRP_W-1:0] mapGroup(input logic unit, input logic dataSide,
                                                input logic sel);
    if (!dataSide) return unit ? GRP_ACC : GRP_ADR;
    return (unit ^ sel) ? GRP_PONG : GRP_PING;
  endfunction
endpackage

// File: rtl/pprf_halfbank.sv
module pprf_halfbank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int NRD    = 2,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [IW-1:0]               wrIdx,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [NRD-1:0][IW-1:0]      rdIdx,
  output logic [NRD-1:0][DATA_W-1:0]  rdData
);
  logic [DEPTH-1:0][DATA_W-1:0] mem;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mem <= '0;
    else if (wrEn) mem[wrIdx] <= wrData;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdData[p] = mem[rdIdx[p]];
  end
endmodule

// File: rtl/pprf_ctrl.sv
module pprf_ctrl
  import pprf_pkg::*;
(
  input  logic                                             bankSel,
  input  logic [NUM_UNITS-1:0][RD_PORTS-1:0][ADDR_W-1:0]   rdAddr,
  input  logic [NUM_UNITS-1:0]                             pairEn,
  input  logic [NUM_UNITS-1:0][ADDR_W-1:0]                 pairAddr,
  input  logic [NUM_UNITS-1:0][SGL_PORTS-1:0]              sglEn,
  input  logic [NUM_UNITS-1:0][SGL_PORTS-1:0][ADDR_W-1:0]  sglAddr,
  output ctrlStrb_t                                        strb,
  output logic [NUM_UNITS-1:0]                             wrErr
);
  localparam int NREQ = SGL_PORTS + 1;

  logic [NUM_UNITS-1:0][NUM_GROUPS-1:0][1:0][1:0] hitCnt;
  wrStrb_t [NUM_UNITS-1:0][NUM_GROUPS-1:0][1:0]   cand;

  always_comb begin
    strb   = '0;
    wrErr  = '0;
    hitCnt = '0;
    cand   = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      // expand the pair port and the single ports into half-bank hits
      for (int k = 0; k < NREQ; k++) begin
        logic              en;
        logic [ADDR_W-1:0] a;
        logic [GRP_W-1:0]  g;
        en = (k == 0) ? pairEn[u] : sglEn[u][k-1];
        a  = (k == 0) ? pairAddr[u] : sglAddr[u][k-1];
        g  = mapGroup(u[0], a[ADDR_W-1], bankSel);
        for (int h = 0; h < 2; h++) begin
          if (en && (k == 0 || a[0] == h[0])) begin
            hitCnt[u][g][h] = hitCnt[u][g][h] + 2'd1;
            cand[u][g][h]   = '{en: 1'b1, idx: a[IDX_W:1], unit: u[0], src: k[SRC_W-1:0]};
          end
        end
      end
      wrErr[u] = pairEn[u] & pairAddr[u][0];
      for (int g = 0; g < NUM_GROUPS; g++)
        for (int h = 0; h < 2; h++)
          if (hitCnt[u][g][h] > 2'd1) wrErr[u] = 1'b1;
      for (int g = 0; g < NUM_GROUPS; g++)
        for (int h = 0; h < 2; h++)
          if (!wrErr[u] && cand[u][g][h].en) strb.wr[g][h] = cand[u][g][h];
      // read routing: each group has a single owner, so ports never collide
      for (int p = 0; p < RD_PORTS; p++) begin
        logic [GRP_W-1:0] rg;
        rg = mapGroup(u[0], rdAddr[u][p][ADDR_W-1], bankSel);
        strb.rdGrp[u][p]  = rg;
        strb.rdIdx[rg][p] = rdAddr[u][p][IDX_W:1];
      end
    end
  end
endmodule

// File: rtl/pprf_datapath.sv
module pprf_datapath
  import pprf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                                                clk,
  input  logic                                                rstN,
  input  ctrlStrb_t                                           strb,
  input  logic [NUM_UNITS-1:0][2*DATA_W-1:0]                  pairData,
  input  logic [NUM_UNITS-1:0][SGL_PORTS-1:0][DATA_W-1:0]     sglData,
  output logic [NUM_UNITS-1:0][RD_PORTS-1:0][2*DATA_W-1:0]    rdData
);
  logic [NUM_GROUPS-1:0][1:0][RD_PORTS-1:0][DATA_W-1:0] hbOut;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar h = 0; h < 2; h++) begin : g_half
      logic [DATA_W-1:0] wdat;
      always_comb begin
        if (strb.wr[g][h].src == '0)
          wdat = pairData[strb.wr[g][h].unit][h*DATA_W +: DATA_W];
        else
          wdat = sglData[strb.wr[g][h].unit][strb.wr[g][h].src - 1'b1];
      end
      pprf_halfbank #(.DATA_W(DATA_W), .DEPTH(HALF_DEPTH), .NRD(RD_PORTS)) hb_i (
        .clk   (clk),
        .rstN  (rstN),
        .wrEn  (strb.wr[g][h].en),
        .wrIdx (strb.wr[g][h].idx),
        .wrData(wdat),
        .rdIdx (strb.rdIdx[g]),
        .rdData(hbOut[g][h])
      );
    end
  end

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++)
      for (int p = 0; p < RD_PORTS; p++)
        rdData[u][p] = {hbOut[strb.rdGrp[u][p]][1][p], hbOut[strb.rdGrp[u][p]][0][p]};
  end
endmodule

// File: rtl/pingpong_rf.sv
module pingpong_rf
  import pprf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  bankSel,
  input  logic [ADDR_W-1:0]                     lsRdAddrA,
  input  logic [ADDR_W-1:0]                     lsRdAddrB,
  output logic [2*DATA_W-1:0]                   lsRdDataA,
  output logic [2*DATA_W-1:0]                   lsRdDataB,
  input  logic                                  lsPairWrEn,
  input  logic [ADDR_W-1:0]                     lsPairWrAddr,
  input  logic [2*DATA_W-1:0]                   lsPairWrData,
  input  logic [SGL_PORTS-1:0]                  lsSglWrEn,
  input  logic [SGL_PORTS-1:0][ADDR_W-1:0]      lsSglWrAddr,
  input  logic [SGL_PORTS-1:0][DATA_W-1:0]      lsSglWrData,
  output logic                                  lsWrErr,
  input  logic [ADDR_W-1:0]                     auRdAddrA,
  input  logic [ADDR_W-1:0]                     auRdAddrB,
  output logic [2*DATA_W-1:0]                   auRdDataA,
  output logic [2*DATA_W-1:0]                   auRdDataB,
  input  logic                                  auPairWrEn,
  input  logic [ADDR_W-1:0]                     auPairWrAddr,
  input  logic [2*DATA_W-1:0]                   auPairWrData,
  input  logic [SGL_PORTS-1:0]                  auSglWrEn,
  input  logic [SGL_PORTS-1:0][ADDR_W-1:0]      auSglWrAddr,
  input  logic [SGL_PORTS-1:0][DATA_W-1:0]      auSglWrData,
  output logic                                  auWrErr
);
  ctrlStrb_t                                               strb;
  logic [NUM_UNITS-1:0]                                    wrErr;
  logic [NUM_UNITS-1:0][RD_PORTS-1:0][2*DATA_W-1:0]        rdData;

  pprf_ctrl ctrl_i (
    .bankSel (bankSel),
    .rdAddr  ({{auRdAddrB, auRdAddrA}, {lsRdAddrB, lsRdAddrA}}),
    .pairEn  ({auPairWrEn, lsPairWrEn}),
    .pairAddr({auPairWrAddr, lsPairWrAddr}),
    .sglEn   ({auSglWrEn, lsSglWrEn}),
    .sglAddr ({auSglWrAddr, lsSglWrAddr}),
    .strb    (strb),
    .wrErr   (wrErr)
  );

  pprf_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .pairData({auPairWrData, lsPairWrData}),
    .sglData ({auSglWrData, lsSglWrData}),
    .rdData  (rdData)
  );

  assign lsRdDataA = rdData[0][0];
  assign lsRdDataB = rdData[0][1];
  assign auRdDataA = rdData[1][0];
  assign auRdDataB = rdData[1][1];
  assign lsWrErr   = wrErr[0];
  assign auWrErr   = wrErr[1];
endmodule

// File: rtl/pprf_checker.sv
module pprf_checker #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                bankSel,
  input logic                lsPairWrEn,
  input logic [3:0]          lsPairWrAddr,
  input logic [2*DATA_W-1:0] lsPairWrData,
  input logic                lsWrErr,
  input logic [3:0]          lsRdAddrA,
  input logic [2*DATA_W-1:0] lsRdDataA,
  input logic                auPairWrEn,
  input logic [3:0]          auPairWrAddr,
  input logic [2*DATA_W-1:0] auPairWrData,
  input logic                auWrErr,
  input logic [3:0]          auRdAddrA,
  input logic [2*DATA_W-1:0] auRdDataA
);
  // R6
  lsOddPairErr_chk: assert property (@(posedge clk) disable iff (!rstN)
    lsPairWrEn && lsPairWrAddr[0] |-> lsWrErr);

  // R6
  auOddPairErr_chk: assert property (@(posedge clk) disable iff (!rstN)
    auPairWrEn && auPairWrAddr[0] |-> auWrErr);

  // R7
  lsErrHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && lsWrErr) && $stable(bankSel) && $stable(lsRdAddrA) |-> $stable(lsRdDataA));

  // R5
  lsPairLands_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && lsPairWrEn && !lsWrErr) && $stable(bankSel) &&
    lsRdAddrA == $past(lsPairWrAddr) |-> lsRdDataA == $past(lsPairWrData));

  // R5
  auPairLands_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && auPairWrEn && !auWrErr) && $stable(bankSel) &&
    auRdAddrA == $past(auPairWrAddr) |-> auRdDataA == $past(auPairWrData));

  // R11
  swapHandoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && lsPairWrEn && !lsWrErr && lsPairWrAddr[3]) && bankSel != $past(bankSel) &&
    auRdAddrA == $past(lsPairWrAddr) |-> auRdDataA == $past(lsPairWrData));
endmodule

bind pingpong_rf pprf_checker #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .bankSel     (bankSel),
  .lsPairWrEn  (lsPairWrEn),
  .lsPairWrAddr(lsPairWrAddr),
  .lsPairWrData(lsPairWrData),
  .lsWrErr     (lsWrErr),
  .lsRdAddrA   (lsRdAddrA),
  .lsRdDataA   (lsRdDataA),
  .auPairWrEn  (auPairWrEn),
  .auPairWrAddr(auPairWrAddr),
  .auPairWrData(auPairWrData),
  .auWrErr     (auWrErr),
  .auRdAddrA   (auRdAddrA),
  .auRdDataA   (auRdDataA)
);

// File: tb/pingpong_rf_tb_top.sv
module pingpong_rf_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bankSel = 1'b0;
  logic [3:0]       rdAddr   [2][2];
  logic [2*W-1:0]   rdData   [2][2];
  logic             pairEn   [2];
  logic [3:0]       pairAddr [2];
  logic [2*W-1:0]   pairData [2];
  logic [1:0]       sglEn    [2];
  logic [1:0][3:0]  sglAddr  [2];
  logic [1:0][W-1:0] sglData [2];
  logic             wrErr    [2];

  logic [W-1:0] model [4][8];
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pingpong_rf #(.DATA_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .bankSel(bankSel),
    .lsRdAddrA(rdAddr[0][0]), .lsRdAddrB(rdAddr[0][1]),
    .lsRdDataA(rdData[0][0]), .lsRdDataB(rdData[0][1]),
    .lsPairWrEn(pairEn[0]), .lsPairWrAddr(pairAddr[0]), .lsPairWrData(pairData[0]),
    .lsSglWrEn(sglEn[0]), .lsSglWrAddr(sglAddr[0]), .lsSglWrData(sglData[0]),
    .lsWrErr(wrErr[0]),
    .auRdAddrA(rdAddr[1][0]), .auRdAddrB(rdAddr[1][1]),
    .auRdDataA(rdData[1][0]), .auRdDataB(rdData[1][1]),
    .auPairWrEn(pairEn[1]), .auPairWrAddr(pairAddr[1]), .auPairWrData(pairData[1]),
    .auSglWrEn(sglEn[1]), .auSglWrAddr(sglAddr[1]), .auSglWrData(sglData[1]),
    .auWrErr(wrErr[1])
  );

  // physical group: 0 address, 1 accumulator, 2 ping, 3 pong
  function automatic int grpOf(int u, logic [3:0] a);
    if (!a[3]) return u;
    if (bankSel == 1'b0) return (u == 0) ? 2 : 3;
    return (u == 0) ? 3 : 2;
  endfunction

  function automatic bit refErr(int u);
    logic [3:0] ad [3];
    bit en [3];
    if (pairEn[u] && pairAddr[u][0]) return 1;
    ad[0] = pairAddr[u];   en[0] = pairEn[u];
    ad[1] = sglAddr[u][0]; en[1] = sglEn[u][0];
    ad[2] = sglAddr[u][1]; en[2] = sglEn[u][1];
    for (int i = 0; i < 3; i++)
      for (int j = i + 1; j < 3; j++)
        if (en[i] && en[j] && grpOf(u, ad[i]) == grpOf(u, ad[j]) &&
            (i == 0 || ad[i][0] == ad[j][0])) return 1;
    return 0;
  endfunction

  function automatic logic [2*W-1:0] refRead(int u, logic [3:0] a);
    int g = grpOf(u, a);
    return {model[g][{a[2:1], 1'b1}], model[g][{a[2:1], 1'b0}]};
  endfunction

  task automatic idle();
    for (int u = 0; u < 2; u++) begin
      pairEn[u] = 0; pairAddr[u] = 0; pairData[u] = 0;
      sglEn[u] = 0; sglAddr[u] = '0; sglData[u] = '0;
      rdAddr[u][0] = 0; rdAddr[u][1] = 0;
    end
  endtask

  task automatic check(string tag, string what, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // called just after a negedge with inputs applied; ends at the next negedge
  task automatic step(string tag);
    bit e [2];
    #2;
    for (int u = 0; u < 2; u++) begin
      check(tag, u ? "au rdA" : "ls rdA", rdData[u][0], refRead(u, rdAddr[u][0]));
      check(tag, u ? "au rdB" : "ls rdB", rdData[u][1], refRead(u, rdAddr[u][1]));
      check(tag, u ? "au err" : "ls err", {63'd0, wrErr[u]}, {63'd0, refErr(u)});
      e[u] = refErr(u);
    end
    @(posedge clk);
    for (int u = 0; u < 2; u++) begin
      if (!e[u]) begin
        if (pairEn[u]) begin
          model[grpOf(u, pairAddr[u])][{pairAddr[u][2:1], 1'b0}] = pairData[u][W-1:0];
          model[grpOf(u, pairAddr[u])][{pairAddr[u][2:1], 1'b1}] = pairData[u][2*W-1:W];
        end
        for (int s = 0; s < 2; s++)
          if (sglEn[u][s]) model[grpOf(u, sglAddr[u][s])][sglAddr[u][s][2:0]] = sglData[u][s];
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int g = 0; g < 4; g++) for (int r = 0; r < 8; r++) model[g][r] = '0;
    idle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: all zero after reset
    rdAddr[0][0] = 0; rdAddr[0][1] = 8; rdAddr[1][0] = 6; rdAddr[1][1] = 14;
    step("R1");
    // R5 R2: LS pair write into d0/d1 with index 0 (ping)
    idle(); pairEn[0] = 1; pairAddr[0] = 8; pairData[0] = 64'h1111_0001_2222_0000;
    step("R5");
    idle(); rdAddr[0][0] = 8; rdAddr[1][0] = 8;
    step("R2");
    bankSel = 1; rdAddr[0][0] = 8; rdAddr[1][0] = 8;
    step("R2");
    // R3: same private name in both units
    idle(); sglEn[0] = 2'b01; sglAddr[0][0] = 2; sglData[0][0] = 32'hA0A0_0002;
    sglEn[1] = 2'b01; sglAddr[1][0] = 2; sglData[1][0] = 32'hC0C0_0002;
    step("R3");
    idle(); rdAddr[0][0] = 2; rdAddr[1][0] = 3;
    step("R3");
    // R8: dual load, index 0
    bankSel = 0; idle();
    pairEn[0] = 1; pairAddr[0] = 10; pairData[0] = 64'h3333_0003_4444_0002;
    sglEn[0] = 2'b11; sglAddr[0][0] = 0; sglAddr[0][1] = 5;
    sglData[0][0] = 32'h0000_1004; sglData[0][1] = 32'h0000_2004;
    step("R8");
    idle(); rdAddr[0][0] = 10; rdAddr[0][1] = 4;
    step("R8");
    // R9: dual MAC on AU, index 1 so AU sees ping
    bankSel = 1; idle();
    rdAddr[1][0] = 8; rdAddr[1][1] = 10;
    pairEn[1] = 1; pairAddr[1] = 4; pairData[1] = 64'h0055_0000_0044_0000;
    step("R9");
    idle(); rdAddr[1][0] = 4; rdAddr[1][1] = 8;
    step("R9");
    // R6: odd pair base blocks the whole LS request
    idle(); pairEn[0] = 1; pairAddr[0] = 9; pairData[0] = 64'hDEAD_DEAD_BEEF_BEEF;
    sglEn[0] = 2'b01; sglAddr[0][0] = 1; sglData[0][0] = 32'hBAD0_0001;
    step("R6");
    idle(); rdAddr[0][0] = 8; rdAddr[0][1] = 0;
    step("R6");
    // R7: same-parity conflict on LS, AU write in the same cycle unaffected
    idle(); sglEn[0] = 2'b11; sglAddr[0][0] = 12; sglAddr[0][1] = 14;
    sglData[0][0] = 32'hBAD0_000C; sglData[0][1] = 32'hBAD0_000E;
    sglEn[1] = 2'b01; sglAddr[1][0] = 12; sglData[1][0] = 32'h600D_000C;
    step("R7");
    idle(); pairEn[0] = 1; pairAddr[0] = 0; sglEn[0] = 2'b01; sglAddr[0][0] = 3;
    step("R7");
    idle(); rdAddr[0][0] = 12; rdAddr[0][1] = 14; rdAddr[1][0] = 12; rdAddr[1][1] = 0;
    step("R7");
    // R10: read during write returns old value
    idle(); pairEn[0] = 1; pairAddr[0] = 12; pairData[0] = 64'h7777_0007_6666_0006;
    rdAddr[0][0] = 12;
    step("R10");
    idle(); rdAddr[0][0] = 12;
    step("R10");
    // R11: write with index 0, swap on the next packet
    bankSel = 0; idle(); pairEn[0] = 1; pairAddr[0] = 14; pairData[0] = 64'h9999_0009_8888_0008;
    step("R11");
    bankSel = 1; idle(); rdAddr[0][0] = 14; rdAddr[1][0] = 14;
    step("R11");
    // R4: mixed traffic, legal and illegal
    for (int n = 0; n < 600; n++) begin
      bankSel = $urandom_range(0, 1);
      for (int u = 0; u < 2; u++) begin
        rdAddr[u][0] = 4'($urandom); rdAddr[u][1] = 4'($urandom);
        pairEn[u] = ($urandom_range(0, 2) == 0);
        pairAddr[u] = 4'($urandom) & (($urandom_range(0, 7) == 0) ? 4'hF : 4'hE);
        pairData[u] = {$urandom, $urandom};
        sglEn[u] = 2'($urandom);
        sglAddr[u][0] = 4'($urandom); sglAddr[u][1] = 4'($urandom);
        sglData[u][0] = $urandom; sglData[u][1] = $urandom;
      end
      step("R4");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule